// File: doc/BRIEF.md
# Memory Performance Counter Unit

A performance monitor for a memory controller. It holds four counters behind a small word-addressed register bus. Counter 0 counts clock cycles and nothing else. Counters 1 to 3 each count one pulse line of an event vector. An 8-bit code in each counter's control word picks that line. Software sets up each counter through its control word and reads the running values back over the same bus.

The cycle counter gates the whole unit. While it is disabled, or after it has wrapped, no counter advances. A wrap of the cycle counter also raises a level interrupt. Software can preload bits 23:16 of any counter when it enables it, which shortens the time to the cycle counter's wrap. Event counters set a sticky overflow flag when they wrap. By default they stop there until software clears them. A build parameter selects an alternative in which they keep wrapping.

Top module: `perf_cnt_unit`

## Requirements
- R1: After reset, control word 0 reads 0x00000000, control words 1 to 3 read 0x00000002 (clear bit set), every count reads 0 and irq_o is low.
- R2: Control word n sits at byte offset 4*n. Its fields are: bit 0 overflow (read-only), bit 1 clear, bit 2 enable, bits 23:16 preload value, bits 31:24 event code. Bits 15:3 read 0, and the event code of counter 0 always reads 0. Count n reads at byte offset 0x20 + 4*n, zero-extended. A read returns its data on rdata_o in the cycle after the rd_en_i strobe, and rdata_o holds that value until the next strobe.
- R3: Counter 0 advances by one on every clock in which it is enabled and its overflow flag is clear. Its event code has no effect.
- R4: Event counter n advances by one in each cycle in which all of these hold: evt_i[code] is high, the counter is enabled, and the cycle counter is running. A code of NUM_EVT or more never counts.
- R5: When counter 0 wraps, its overflow flag sets, every counter holds its value and irq_o goes high. irq_o stays high until counter 0 is cleared or disabled. Disabling counter 0 clears its flag, and re-enabling it resumes counting.
- R6: While counter 0 is disabled, no event counter changes.
- R7: An event counter that wraps sets its overflow flag. With WRAP_ON_OVF=0 it then holds at 0. With WRAP_ON_OVF=1 it keeps counting and the flag stays set.
- R8: Counter 0 clears only when a write sets bit 1 while the stored bit 1 is 0. A write of 1 over a stored 1 leaves the count unchanged.
- R9: A write of 0 to bit 1 of an event counter's control word zeroes that counter and its overflow flag, and bit 1 then reads back as 1. A clear wins over an event in the same cycle.
- R10: A write that turns a counter's enable bit from 0 to 1 loads count bits 23:16 from the written bits 23:16 and keeps the other bits. If the same write clears the counter, the other bits are zero.
- R11: Reads of any other offset return 0, including offsets not a multiple of 4. Writes to those offsets, or to the count offsets, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after rd_en_i |
| evt_i | input | NUM_EVT | Event pulses, one line per event code |
| irq_o | output | 1 | Level interrupt: counter 0 has wrapped |

## Verification
The bench first uses preloads to reach both kinds of wrap within the run. It then restarts the cycle counter so that an event counter wraps first. This separates a design that stops the event counter at 0 from one that keeps wrapping, and a unit that fails to freeze on the later cycle wrap shows a moving count. It writes a clear bit of 1 twice over a stored 1 and expects no clear; a design that treats the level, rather than the rising edge, as the clear would zero the count. It clears an event counter in the same cycle as an event, and it writes to count offsets and misaligned offsets; a design with the wrong priority or a loose decode would leave a non-zero or altered count. It also enables a counter that already holds a value, which shows whether the preload keeps the low bits.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int NUM_CNT  = 4;
  localparam int BIT_OVF  = 0;
  localparam int BIT_CLR  = 1;
  localparam int BIT_EN   = 2;
  localparam int CP_LSB   = 16;
  localparam int CP_W     = 8;
  localparam int SEL_LSB  = 24;
  localparam int SEL_W    = 8;
  localparam int CTRL_BASE = 'h00;
  localparam int CNT_BASE  = 'h20;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/perf_cnt_slice.sv
module perf_cnt_slice
  import perf_cnt_pkg::*;
#(
  parameter bit IS_CYCLE    = 1'b0,
  parameter int NUM_EVT     = 64,
  parameter bit WRAP_ON_OVF = 1'b0,
  parameter int CNT_W       = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  word_t              wdata_i,
  input  logic               run_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [CNT_W-1:0]   cnt_o,
  output word_t              ctrl_o,
  output logic               run_o
);
  logic             en_q, clr_q, ovf_q;
  logic [CP_W-1:0]  cp_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit, stall, inc, wrap, en_rise, do_clr, ovf_rel;
  logic             w_en, w_clr;
  logic             unused_wdata;

  assign w_en  = wdata_i[BIT_EN];
  assign w_clr = wdata_i[BIT_CLR];
  assign unused_wdata = ^{wdata_i[CP_LSB-1:BIT_EN+1], wdata_i[BIT_OVF]};

  if (IS_CYCLE) begin : g_cyc
    logic unused_in;
    assign unused_in = ^evt_i;
    assign hit = 1'b1;
  end else begin : g_evt
    logic [255:0] evt_pad;
    assign evt_pad = 256'(evt_i);
    assign hit = evt_pad[sel_q];
  end

  assign stall   = ovf_q && (IS_CYCLE || !WRAP_ON_OVF);
  assign inc     = en_q && run_i && hit && !stall;
  assign wrap    = inc && (&cnt_q);
  assign en_rise = wr_i && w_en && !en_q;
  // cycle counter clears on a 0->1 of the stored bit, event counters on a written 0
  assign do_clr  = wr_i && (IS_CYCLE ? (w_clr && !clr_q) : !w_clr);
  assign ovf_rel = do_clr || (IS_CYCLE && wr_i && !w_en);

  always_comb begin
    cnt_d = cnt_q;
    if (do_clr)   cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
    if (en_rise)  cnt_d[CP_LSB +: CP_W] = wdata_i[CP_LSB +: CP_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      clr_q <= !IS_CYCLE;
      ovf_q <= 1'b0;
      cp_q  <= '0;
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (ovf_rel)   ovf_q <= 1'b0;
      else if (wrap) ovf_q <= 1'b1;
      if (wr_i) begin
        en_q  <= w_en;
        clr_q <= IS_CYCLE ? w_clr : 1'b1;
        cp_q  <= wdata_i[CP_LSB +: CP_W];
        sel_q <= wdata_i[SEL_LSB +: SEL_W];
      end
    end
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o[BIT_OVF] = ovf_q;
    ctrl_o[BIT_CLR] = clr_q;
    ctrl_o[BIT_EN]  = en_q;
    ctrl_o[CP_LSB +: CP_W]   = cp_q;
    ctrl_o[SEL_LSB +: SEL_W] = IS_CYCLE ? '0 : sel_q;
  end

  assign cnt_o = cnt_q;
  assign run_o = en_q && !ovf_q;

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R4

  AST_ENABLE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && w_en && !en_q) |=> cnt_q[CP_LSB +: CP_W] == $past(wdata_i[CP_LSB +: CP_W])); // R10

  if (!IS_CYCLE) begin : g_evt_ast
    AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !wdata_i[BIT_CLR] && !(wdata_i[BIT_EN] && !en_q)) |=> (cnt_q == '0 && !ovf_q)); // R9
    AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !wr_i) |=> $stable(cnt_q)); // R6
    if (!WRAP_ON_OVF) begin : g_stop_ast
      AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_q && !wr_i) |=> ($stable(cnt_q) && ovf_q)); // R7
    end
  end
endmodule

// File: rtl/perf_cnt_bus.sv
module perf_cnt_bus
  import perf_cnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic                            rd_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  word_t [NUM_CNT-1:0]             ctrl_i,
  input  logic  [NUM_CNT-1:0][CNT_W-1:0]  cnt_i,
  output logic  [NUM_CNT-1:0]             ctrl_wr_o,
  output word_t                           rdata_o
);
  localparam int WORD_W    = ADDR_W - 2;
  localparam int CTRL_WORD = CTRL_BASE / 4;
  localparam int CNT_WORD  = CNT_BASE / 4;

  logic [WORD_W-1:0] word;
  logic              aligned, mapped;
  word_t             rd_val, rdata_q;

  assign word    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    ctrl_wr_o = '0;
    rd_val    = '0;
    mapped    = 1'b0;
    for (int n = 0; n < NUM_CNT; n++) begin
      if (aligned && word == WORD_W'(CTRL_WORD + n)) begin
        ctrl_wr_o[n] = wr_en_i;
        rd_val       = ctrl_i[n];
        mapped       = 1'b1;
      end
      if (aligned && word == WORD_W'(CNT_WORD + n)) begin
        rd_val = DATA_W'(cnt_i[n]);
        mapped = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !mapped) |=> rdata_o == '0); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R2
endmodule

// File: rtl/perf_cnt_unit.sv
module perf_cnt_unit
  import perf_cnt_pkg::*;
#(
  parameter int NUM_EVT     = 64,
  parameter int CNT_W       = 32,
  parameter bit WRAP_ON_OVF = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [7:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_o
);
  word_t [NUM_CNT-1:0]            ctrl_v;
  logic  [NUM_CNT-1:0][CNT_W-1:0] cnt_v;
  logic  [NUM_CNT-1:0]            wr_v, run_v;
  logic                           unused_run;

  perf_cnt_bus #(.CNT_W(CNT_W)) u_bus (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i,
    .ctrl_i(ctrl_v), .cnt_i(cnt_v), .ctrl_wr_o(wr_v), .rdata_o
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    perf_cnt_slice #(
      .IS_CYCLE(n == 0), .NUM_EVT(NUM_EVT),
      .WRAP_ON_OVF(WRAP_ON_OVF), .CNT_W(CNT_W)
    ) u_slice (
      .clk_i, .rst_ni,
      .wr_i(wr_v[n]), .wdata_i,
      .run_i((n == 0) ? 1'b1 : run_v[0]),
      .evt_i, .cnt_o(cnt_v[n]), .ctrl_o(ctrl_v[n]), .run_o(run_v[n])
    );
  end

  assign unused_run = ^run_v[NUM_CNT-1:1];
  assign irq_o      = ctrl_v[0][BIT_OVF];

  AST_IRQ_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_en_i) |=> $stable(cnt_v)); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_en_i) |=> irq_o); // R5
endmodule

// File: tb/perf_cnt_unit_bench.sv
module perf_cnt_unit_bench;
  localparam int NE   = 16;
  localparam int CW   = 24;
  localparam int MAXC = (1 << CW) - 1;

  logic        clk_i = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_wr = 1'b0, b_rd = 1'b0;
  logic [7:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [NE-1:0] b_evt = '0;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;

  int checks = 0;
  int fails  = 0;

  always #2.5ns clk_i = ~clk_i;

  perf_cnt_unit #(.NUM_EVT(NE), .CNT_W(CW), .WRAP_ON_OVF(1'b0)) u_perf_cnt_unit (
    .clk_i, .rst_ni(rst_n), .wr_en_i(b_wr), .rd_en_i(b_rd), .addr_i(b_addr),
    .wdata_i(b_wdata), .rdata_o(rdata0), .evt_i(b_evt), .irq_o(irq0));

  perf_cnt_unit #(.NUM_EVT(NE), .CNT_W(CW), .WRAP_ON_OVF(1'b1)) u_perf_cnt_unit_wrap (
    .clk_i, .rst_ni(rst_n), .wr_en_i(b_wr), .rd_en_i(b_rd), .addr_i(b_addr),
    .wdata_i(b_wdata), .rdata_o(rdata1), .evt_i(b_evt), .irq_o(irq1));

  // behavioural reference, index [instance][counter]; instance 1 keeps wrapping
  bit          m_en [2][4];
  bit          m_clr[2][4];
  bit          m_ovf[2][4];
  int unsigned m_cp [2][4];
  int unsigned m_sel[2][4];
  int unsigned m_cnt[2][4];
  logic [31:0] m_rd [2];

  function automatic logic [31:0] m_read(int d, logic [7:0] a);
    int w;
    if (a[1:0] != 2'b00) return 32'h0;
    w = int'(a[7:2]);
    if (w < 4)
      return {(w == 0) ? 8'h00 : 8'(m_sel[d][w]), 8'(m_cp[d][w]), 13'h0,
              m_en[d][w], m_clr[d][w], m_ovf[d][w]};
    if (w >= 8 && w < 12) return m_cnt[d][w-8];
    return 32'h0;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        m_rd[d] = '0;
        for (int n = 0; n < 4; n++) begin
          m_en[d][n] = 0; m_clr[d][n] = (n != 0); m_ovf[d][n] = 0;
          m_cp[d][n] = 0; m_sel[d][n] = 0; m_cnt[d][n] = 0;
        end
      end
    end else begin
      for (int d = 0; d < 2; d++) begin
        bit run0;
        run0 = m_en[d][0] && !m_ovf[d][0];
        if (b_rd) m_rd[d] = m_read(d, b_addr);
        for (int n = 0; n < 4; n++) begin
          bit wrn, hit, stall, inc, wrap, rise, clr, rel, we, wc;
          int unsigned nc;
          wrn   = b_wr && (b_addr == 8'(4 * n));
          hit   = (n == 0) ? 1'b1 : ((m_sel[d][n] < NE) ? b_evt[m_sel[d][n]] : 1'b0);
          stall = m_ovf[d][n] && (n == 0 || d == 0);
          inc   = m_en[d][n] && (n == 0 || run0) && hit && !stall;
          wrap  = inc && (m_cnt[d][n] == MAXC);
          we    = b_wdata[2];
          wc    = b_wdata[1];
          rise  = wrn && we && !m_en[d][n];
          clr   = wrn && ((n == 0) ? (wc && !m_clr[d][n]) : !wc);
          rel   = clr || (n == 0 && wrn && !we);
          nc = m_cnt[d][n];
          if (clr) nc = 0;
          else if (inc) nc = (nc + 1) & MAXC;
          if (rise) nc = (nc & ~32'h00FF_0000) | (32'(b_wdata[23:16]) << 16);
          m_cnt[d][n] = nc & MAXC;
          if (rel) m_ovf[d][n] = 0;
          else if (wrap) m_ovf[d][n] = 1;
          if (wrn) begin
            m_en[d][n]  = we;
            m_clr[d][n] = (n == 0) ? wc : 1'b1;
            m_cp[d][n]  = b_wdata[23:16];
            m_sel[d][n] = b_wdata[31:24];
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison with the reference
  always @(negedge clk_i) begin
    if (rst_n) begin
      chk("R5 irq", 32'(irq0), 32'(m_ovf[0][0]));
      chk("R5 irq wrap", 32'(irq1), 32'(m_ovf[1][0]));
      chk("R2 rdata", rdata0, m_rd[0]);
      chk("R2 rdata wrap", rdata1, m_rd[1]);
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] v);
    b_wr = 1'b1; b_addr = a; b_wdata = v;
    @(negedge clk_i);
    b_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] v0, output logic [31:0] v1);
    b_rd = 1'b1; b_addr = a;
    @(negedge clk_i);
    b_rd = 1'b0;
    v0 = rdata0; v1 = rdata1;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] a0, a1, c0, c1;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int n = 0; n < 4; n++) begin
      rd_reg(8'(4 * n), a0, a1);
      chk("R1 ctrl", a0, (n == 0) ? 32'h0 : 32'h2);
      rd_reg(8'(8'h20 + 4 * n), a0, a1);
      chk("R1 count", a0, 32'h0);
    end
    chk("R1 irq", 32'(irq0), 32'h0);

    // R2 field layout, read-only overflow bit, counter 0 code forced to 0
    wr_reg(8'h04, 32'h0312_0003);
    rd_reg(8'h04, a0, a1);
    chk("R2 ctrl1", a0, 32'h0312_0002);
    wr_reg(8'h00, 32'h5500_0000);
    rd_reg(8'h00, a0, a1);
    chk("R2 ctrl0 code", a0, 32'h0);

    // R11 unmapped reads
    rd_reg(8'h10, a0, a1); chk("R11 read 0x10", a0, 32'h0);
    rd_reg(8'h30, a0, a1); chk("R11 read 0x30", a0, 32'h0);
    rd_reg(8'h05, a0, a1); chk("R11 read 0x05", a0, 32'h0);
    rd_reg(8'hFC, a0, a1); chk("R11 read 0xFC", a0, 32'h0);

    // R4 event counting: code 3, code 20 (out of range), code 5
    wr_reg(8'h04, 32'h0300_0006);
    wr_reg(8'h08, 32'h1400_0006);
    wr_reg(8'h0C, 32'h0500_0006);
    wr_reg(8'h00, 32'h5500_0006);
    rd_reg(8'h00, a0, a1);
    chk("R3 ctrl0 enabled", a0, 32'h0000_0006);
    for (int i = 0; i < 10; i++) begin
      b_evt = NE'(1 << 3) | ((i % 2 == 0) ? NE'(1 << 5) : NE'(0));
      @(negedge clk_i);
    end
    b_evt = '0;
    rd_reg(8'h24, a0, a1); chk("R4 cnt1", a0, 32'd10);
    rd_reg(8'h28, a0, a1); chk("R4 cnt2 code out of range", a0, 32'd0);
    rd_reg(8'h2C, a0, a1); chk("R4 cnt3", a0, 32'd5);

    // R3 cycle counter steps every clock, code ignored
    rd_reg(8'h20, c0, a1);
    rd_reg(8'h20, c1, a1);
    chk("R3 cycle step", c1 - c0, 32'd1);

    // R6 cycle disable halts everything
    wr_reg(8'h00, 32'h0000_0002);
    b_evt = NE'(1 << 3);
    idle(5);
    b_evt = '0;
    rd_reg(8'h24, a0, a1); chk("R6 cnt1 held", a0, 32'd10);
    rd_reg(8'h20, c0, a1);
    rd_reg(8'h20, c1, a1);
    chk("R6 cycle held", c1 - c0, 32'd0);

    // R8 cycle clear needs a 0->1 of the stored bit
    wr_reg(8'h00, 32'h0000_0002);
    rd_reg(8'h20, a0, a1);
    chk("R8 no clear on 1 over 1", a0, c1);
    wr_reg(8'h00, 32'h0000_0000);
    wr_reg(8'h00, 32'h0000_0002);
    rd_reg(8'h20, a0, a1);
    chk("R8 clear on rise", a0, 32'h0);
    wr_reg(8'h00, 32'h0000_0004);

    // R9 event clear wins over a same-cycle event, bit reads back 1
    b_evt = NE'(1 << 3);
    wr_reg(8'h04, 32'h0300_0004);
    b_evt = '0;
    rd_reg(8'h04, a0, a1); chk("R9 clr reads 1", a0, 32'h0300_0006);
    rd_reg(8'h24, a0, a1); chk("R9 clear wins", a0, 32'h0);

    // R11 writes to count, misaligned and unmapped offsets ignored
    wr_reg(8'h2C, 32'h0);
    wr_reg(8'h0F, 32'h0);
    wr_reg(8'h1C, 32'h0);
    rd_reg(8'h2C, a0, a1); chk("R11 cnt3 kept", a0, 32'd5);
    rd_reg(8'h0C, a0, a1); chk("R11 ctrl3 kept", a0, 32'h0500_0006);

    // R10 preload keeps the low bits
    wr_reg(8'h0C, 32'h0500_0002);
    wr_reg(8'h0C, 32'h05A5_0006);
    rd_reg(8'h2C, a0, a1); chk("R10 preload", a0, 32'h00A5_0005);
    rd_reg(8'h0C, a0, a1); chk("R10 ctrl3", a0, 32'h05A5_0006);

    // R7 / R5 overflow: event counter 1 wraps first, then the cycle counter
    wr_reg(8'h04, 32'h03FF_0002);
    wr_reg(8'h04, 32'h03FF_0004);
    rd_reg(8'h24, a0, a1); chk("R10 clear with preload", a0, 32'h00FF_0000);
    b_evt = NE'(1 << 3);
    idle(30000);
    wr_reg(8'h00, 32'h00FF_0000);
    wr_reg(8'h00, 32'h00FF_0006);
    idle(40000);
    rd_reg(8'h04, a0, a1);
    chk("R7 ovf flag", a0, 32'h03FF_0007);
    chk("R7 ovf flag wrap", a1, 32'h03FF_0007);
    rd_reg(8'h24, c0, a0);
    rd_reg(8'h24, c1, a1);
    chk("R7 stopped at 0", c0, 32'h0);
    chk("R7 still stopped", c1, 32'h0);
    chk("R7 legacy keeps counting", a1 - a0, 32'd1);
    chk("R5 irq low before wrap", 32'(irq0), 32'h0);
    idle(30000);
    chk("R5 irq high", 32'(irq0), 32'h1);
    chk("R5 irq high wrap", 32'(irq1), 32'h1);
    rd_reg(8'h20, c0, a0);
    rd_reg(8'h20, c1, a1);
    chk("R5 cycle frozen at 0", c0, 32'h0);
    chk("R5 cycle stays", c1, 32'h0);
    rd_reg(8'h24, c0, a0);
    rd_reg(8'h24, c1, a1);
    chk("R5 event frozen", a1 - a0, 32'd0);
    rd_reg(8'h00, a0, a1); chk("R5 ctrl0", a0, 32'h00FF_0007);
    idle(50);
    chk("R5 irq level", 32'(irq0), 32'h1);
    wr_reg(8'h00, 32'h00FF_0002);
    chk("R5 irq drops on disable", 32'(irq0), 32'h0);
    wr_reg(8'h00, 32'h00FF_0004);
    rd_reg(8'h20, c0, a0);
    rd_reg(8'h20, c1, a1);
    chk("R5 resumes", c1 - c0, 32'd1);
    rd_reg(8'h24, c0, a0);
    rd_reg(8'h24, c1, a1);
    chk("R7 needs clear", c1, 32'h0);
    wr_reg(8'h04, 32'h03FF_0004);
    rd_reg(8'h04, a0, a1); chk("R9 ovf cleared", a0, 32'h03FF_0006);
    rd_reg(8'h24, c0, a0);
    rd_reg(8'h24, c1, a1);
    chk("R9 counts again", c1 - c0, 32'd1);
    b_evt = '0;
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule